// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block turns a 128-bit cipher key into the eleven 128-bit round keys of AES-128, one key per clock step, so that a round controller can pull each key in the same cycle it runs the matching cipher round. A load strobe captures a fresh key and presents it as round key 0. Each advance strobe then derives the next round key from the current one. It uses one 4-byte substitution path, a word rotation and the round constant. After ten advances the last key is out and a done flag is raised.

Every key produced is also written into an on-block schedule store with its own read port. A decrypt pass can then replay the keys from index 10 down to 0 without expanding them again. A load strobe always wins: it aborts any expansion under way and restarts from the new key.

Top module: `aes128_rkgen`

## Requirements
- R1: After reset, `rk_out` is all zeros, `rk_idx` is 0 and `done` is 0.
- R2: One cycle after `key_load` is high, `rk_out` equals the `key_in` value that was sampled, `rk_idx` is 0 and `done` is 0. Word 0 of a key is bits 127:96 and word 3 is bits 31:0.
- R3: While an expansion is running, one cycle after `adv` is high (and `key_load` low), `rk_idx` has gone up by one. `rk_out` holds new words n0..n3 built from the previous words p0..p3 as n0 = p0 ^ t, n1 = p1 ^ n0, n2 = p2 ^ n1, n3 = p3 ^ n2. Here t is the byte substitution of p3 rotated left by one byte, XORed with the round constant in bits 31:24.
- R4: The round constant used to produce round key k (k = 1..10) is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 in hex.
- R5: After exactly ten advances from a load, `rk_idx` is 10 and `done` is 1. `done` is never 1 with any other index.
- R6: An advance while no expansion is running, whether finished or never loaded, has no effect on `rk_out`, `rk_idx` or `done`.
- R7: A load while an expansion is running aborts it. The next cycle shows the new key at index 0, and ten further advances give that key's full schedule.
- R8: Once an expansion has finished, `rd_key` for `rd_idx` = k (0..10) equals round key k of that expansion. Any `rd_idx` above 10 reads all zeros.
- R9: In a cycle with neither `key_load` nor `adv`, `rk_out`, `rk_idx` and `done` hold their values.
- R10: For key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605 and round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Capture `key_in` and restart the schedule |
| key_in | input | 128 | Cipher key |
| adv | input | 1 | Step to the next round key |
| rk_out | output | 128 | Current round key |
| rk_idx | output | 4 | Index of the current round key |
| done | output | 1 | Last round key is on `rk_out` |
| rd_idx | input | 4 | Read index into the schedule store |
| rd_key | output | 128 | Stored round key at `rd_idx` |

## Verification
The assertions assume that `key_load` and `adv` are clean one-cycle-resolved levels with no X. They also assume that a simultaneous load and advance is resolved in favour of the load. The bench drives every strobe on the falling edge. It randomly mixes advances, idle cycles and mid-run reloads, so every mix of the two strobes is reached. Random keys come from a fixed seed, and each expected schedule is computed in the bench by a separate S-box built from a brute-force field inverse.

// File: rtl/rkgen_pkg.sv
package rkgen_pkg;

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
      end
      return acc;
   endfunction

   // forward substitution: field inverse (x^254) then affine map
   function automatic logic [7:0] sub_byte(input logic [7:0] x);
      logic [7:0] sq;
      logic [7:0] inv;
      logic [7:0] y;
      sq  = x;
      inv = 8'h01;
      for (int k = 0; k < 7; k++) begin
         sq  = gf_mul(sq, sq);
         inv = gf_mul(inv, sq);
      end
      y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      return y;
   endfunction

   function automatic logic [7:0] round_const(input logic [3:0] k);
      logic [7:0] c;
      c = 8'h01;
      for (int i = 2; i <= 10; i++)
         if (i <= int'(k)) c = gf_mul(c, 8'h02);
      return c;
   endfunction

endpackage

// File: rtl/rkgen_subword.sv
module rkgen_subword #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int NBYTES = WORD_W / 8;

   if (WORD_W % 8 != 0) begin : g_bad_w
      $error("rkgen_subword: WORD_W must be a multiple of 8");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign dout[b*8 +: 8] = rkgen_pkg::sub_byte(din[b*8 +: 8]);
   end
endmodule

// File: rtl/rkgen_step.sv
module rkgen_step #(
   parameter int KEY_W  = 128,
   parameter int WORD_W = 32
) (
   input  logic [KEY_W-1:0] prev,
   input  logic [7:0]       rcon,
   output logic [KEY_W-1:0] next
);
   localparam int NW = KEY_W / WORD_W;

   logic [WORD_W-1:0] pw [NW];
   logic [WORD_W-1:0] nw [NW];
   logic [WORD_W-1:0] rot;
   logic [WORD_W-1:0] subd;
   logic [WORD_W-1:0] mixed;

   for (genvar i = 0; i < NW; i++) begin : g_split
      assign pw[i] = prev[KEY_W-1-i*WORD_W -: WORD_W];
      assign next[KEY_W-1-i*WORD_W -: WORD_W] = nw[i];
   end

   assign rot = {pw[NW-1][WORD_W-9:0], pw[NW-1][WORD_W-1 -: 8]};

   rkgen_subword #(.WORD_W(WORD_W)) u_sub (.din(rot), .dout(subd));

   assign mixed = subd ^ {rcon, {(WORD_W-8){1'b0}}};

   assign nw[0] = pw[0] ^ mixed;
   for (genvar i = 1; i < NW; i++) begin : g_chain
      assign nw[i] = pw[i] ^ nw[i-1];
   end
endmodule

// File: rtl/rkgen_store.sv
module rkgen_store #(
   parameter int KEY_W   = 128,
   parameter int NKEYS   = 11,
   parameter int IDX_W   = 4,
   parameter bit KEEP_ALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [KEY_W-1:0] wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [KEY_W-1:0] rdata
);
   if (KEEP_ALL) begin : g_keep
      logic [KEY_W-1:0] mem [NKEYS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NKEYS; i++) mem[i] <= '0;
         end else if (we && (int'(widx) < NKEYS)) begin
            mem[widx] <= wdata;
         end
      end

      always_comb begin
         rdata = '0;
         if (int'(ridx) < NKEYS) rdata = mem[ridx];
      end

      // R8: out-of-range reads return zero
      p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(ridx) >= NKEYS) |-> (rdata == '0));
   end else begin : g_none
      assign rdata = '0;
   end
endmodule

// File: rtl/aes128_rkgen.sv
module aes128_rkgen #(
   parameter int KEY_W    = 128,
   parameter int WORD_W   = 32,
   parameter int NROUNDS  = 10,
   parameter bit KEEP_ALL = 1'b1,
   localparam int NKEYS   = NROUNDS + 1,
   localparam int IDX_W   = $clog2(NKEYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_load,
   input  logic [KEY_W-1:0] key_in,
   input  logic             adv,
   output logic [KEY_W-1:0] rk_out,
   output logic [IDX_W-1:0] rk_idx,
   output logic             done,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [KEY_W-1:0] rd_key
);
   if (KEY_W != 128 || WORD_W != 32 || NROUNDS != 10) begin : g_bad_cfg
      $error("aes128_rkgen: only the 128-bit key schedule is supported");
   end

   logic [KEY_W-1:0] rk_q;
   logic [IDX_W-1:0] idx_q;
   logic             busy_q;
   logic             done_q;
   logic [KEY_W-1:0] rk_next;
   logic [IDX_W-1:0] idx_inc;
   logic [7:0]       rcon;
   logic             step;
   logic             st_we;
   logic [IDX_W-1:0] st_widx;
   logic [KEY_W-1:0] st_wdata;

   assign idx_inc = idx_q + 1'b1;
   assign rcon    = rkgen_pkg::round_const(4'(idx_inc));
   assign step    = adv && busy_q && !key_load;

   rkgen_step #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_step (
      .prev (rk_q),
      .rcon (rcon),
      .next (rk_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rk_q   <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (key_load) begin
         rk_q   <= key_in;
         idx_q  <= '0;
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (step) begin
         rk_q  <= rk_next;
         idx_q <= idx_inc;
         if (int'(idx_q) == NROUNDS - 1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign st_we    = key_load || step;
   assign st_widx  = key_load ? '0 : idx_inc;
   assign st_wdata = key_load ? key_in : rk_next;

   rkgen_store #(.KEY_W(KEY_W), .NKEYS(NKEYS), .IDX_W(IDX_W), .KEEP_ALL(KEEP_ALL)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (st_we),
      .widx  (st_widx),
      .wdata (st_wdata),
      .ridx  (rd_idx),
      .rdata (rd_key)
   );

   assign rk_out = rk_q;
   assign rk_idx = idx_q;
   assign done   = done_q;

   // R2: a load presents the new key at index 0
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> (rk_out == $past(key_in)) && (rk_idx == '0) && !done);

   // R3: a running advance bumps the index by one
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !key_load && busy_q) |=> (rk_idx == $past(rk_idx) + 1'b1));

   // R5: done only with the final index
   p_done_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(rk_idx) == NROUNDS));

   // R6: advance outside a run changes nothing
   p_idle_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !key_load && !busy_q) |=> $stable(rk_out) && $stable(rk_idx) && $stable(done));

   // R9: no strobe, no change
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !key_load) |=> $stable(rk_out) && $stable(rk_idx) && $stable(done));
endmodule

// File: tb/aes128_rkgen_tb.sv
module aes128_rkgen_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         key_load = 1'b0;
   logic [127:0] key_in = '0;
   logic         adv = 1'b0;
   logic [127:0] rk_out;
   logic [3:0]   rk_idx;
   logic         done;
   logic [3:0]   rd_idx = '0;
   logic [127:0] rd_key;

   int n_tests = 0;
   int n_fail  = 0;
   logic [127:0] sched [11];

   always #5 clk = ~clk;

   aes128_rkgen u_dut (
      .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in), .adv(adv),
      .rk_out(rk_out), .rk_idx(rk_idx), .done(done), .rd_idx(rd_idx), .rd_key(rd_key)
   );

   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] m_sbox(input logic [7:0] x);
      logic [7:0] inv;
      logic [7:0] r;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
         r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (((8'h63) >> i) & 1'b1);
      return r;
   endfunction

   function automatic logic [7:0] m_rcon(input int k);
      logic [7:0] t [10];
      t = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
      return t[k-1];
   endfunction

   function automatic logic [31:0] m_t(input logic [31:0] w);
      logic [31:0] r;
      r = {w[23:0], w[31:24]};
      return {m_sbox(r[31:24]), m_sbox(r[23:16]), m_sbox(r[15:8]), m_sbox(r[7:0])};
   endfunction

   task automatic build(input logic [127:0] k);
      logic [31:0] w [44];
      for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         if (i % 4 == 0) w[i] = w[i-4] ^ m_t(w[i-1]) ^ {m_rcon(i/4), 24'h0};
         else            w[i] = w[i-4] ^ w[i-1];
      end
      for (int r = 0; r < 11; r++) sched[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
   endtask

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [127:0] k);
      @(negedge clk);
      key_load = 1'b1; key_in = k; adv = 1'b0;
      @(negedge clk);
      key_load = 1'b0;
   endtask

   task automatic do_adv();
      @(negedge clk);
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic full_run(input logic [127:0] k, input bit gaps, input string tag);
      logic [127:0] prev;
      build(k);
      do_load(k);
      chk({tag, " R2 key"}, rk_out, sched[0]);
      chk({tag, " R2 idx/done"}, {rk_idx, done}, {4'd0, 1'b0});
      for (int r = 1; r <= 10; r++) begin
         prev = rk_out;
         if (gaps && ($urandom % 3 == 0)) begin
            idle(1 + $urandom % 3);
            chk({tag, " R9 hold"}, rk_out, prev);
         end
         do_adv();
         chk({tag, " R3 key"}, rk_out, sched[r]);
         chk({tag, " R3 idx"}, 128'(rk_idx), 128'(r));
         // R4: recover the round constant from the new word 0
         chk({tag, " R4 rcon"}, 128'(rk_out[127:96] ^ prev[127:96] ^ m_t(prev[31:0])),
             128'({m_rcon(r), 24'h0}));
         if (r < 10) chk({tag, " R5 early done"}, 128'(done), 128'(0));
      end
      chk({tag, " R5 done"}, {rk_idx, done}, {4'd10, 1'b1});
   endtask

   initial begin
      logic [127:0] k;
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      // R1
      chk("R1 key", rk_out, '0);
      chk("R1 idx/done", {rk_idx, done}, '0);
      rst_n = 1'b1;
      // R6: advance before any load
      do_adv();
      chk("R6 idle key", rk_out, '0);
      chk("R6 idle idx/done", {rk_idx, done}, '0);

      // R10: standard vector
      full_run(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0, "vec");
      chk("R10 rk1", sched[1], 128'ha0fafe1788542cb123a339392a6c7605);
      chk("R10 rk10", rk_out, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

      // R6: advance after completion
      do_adv();
      chk("R6 done key", rk_out, sched[10]);
      chk("R6 done idx/done", {rk_idx, done}, {4'd10, 1'b1});

      // R8: reverse replay and out-of-range reads
      for (int r = 10; r >= 0; r--) begin
         rd_idx = 4'(r);
         #1;
         chk("R8 replay", rd_key, sched[r]);
      end
      for (int r = 11; r < 16; r++) begin
         rd_idx = 4'(r);
         #1;
         chk("R8 oob", rd_key, '0);
      end

      // R7: abort mid-run
      do_load(128'h000102030405060708090a0b0c0d0e0f);
      repeat (4) do_adv();
      full_run(128'hffeeddccbbaa99887766554433221100, 1'b0, "abort");
      rd_idx = 4'd5; #1;
      chk("R7 store after abort", rd_key, sched[5]);

      // R7: load and advance in the same cycle, load wins
      k = {$urandom, $urandom, $urandom, $urandom};
      do_load(k);
      do_adv();
      @(negedge clk);
      key_load = 1'b1; adv = 1'b1; key_in = ~k;
      @(negedge clk);
      key_load = 1'b0; adv = 1'b0;
      chk("R7 load beats adv", rk_out, ~k);
      chk("R7 load idx", 128'(rk_idx), 128'(0));

      // random keys with random gaps
      for (int n = 0; n < 12; n++) begin
         k = {$urandom, $urandom, $urandom, $urandom};
         full_run(k, 1'b1, "rand");
         rd_idx = 4'($urandom % 11); #1;
         chk("R8 rand read", rd_key, sched[rd_idx]);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule